// File: doc/BRIEF.md
# Central Bus Arbitration Controller

This block sequences ownership of a shared bus among as many as sixteen requesters, each identified by a 4-bit priority vector. Requesters pull an active-low preempt line whenever they want the bus. The controller waits until the present owner has finished its transfer. It then raises its arbitration/grant output for a fixed number of clocks. During that window the requesters resolve their vectors on a wired-AND bus. When the output drops back to the grant level, the vector still on the bus becomes the new owner.

A transfer counts as finished once both bus-cycle status lines are inactive and the burst and command lines are both inactive, whichever of those falls last. Vector 0000 has the highest priority and 1111 the lowest. Vector 1111 stands for the host processor, which owns the bus by default and takes it back when no one else competes. Vectors 0000 to 0111 map to DMA channels 0 to 7; DMA execution itself lies outside this block.

A bursting owner that keeps the bus while preempt is pending is allowed a limited time, set in clock cycles from the clock frequency. When that time runs out, the controller takes the bus back by forcing arbitration and raises a sticky error/NMI flag. The flag stays set until it is cleared.

Top module: `bus_arb_central`

## Requirements
- R1: After reset the controller is in the grant state (arb_gnt = 0), owner reads 1111 and tmo_err is 0.
- R2: With owner 1111 and the bus idle, a fall of preempt_n made between clock edges raises arb_gnt on the third rising edge after it. The two edges before that are taken up by the synchroniser.
- R3: arb_gnt stays high for exactly ARB_CYC clock cycles. On the edge that drops it, owner takes the value on arb_bus. An undriven bus reads 1111, which returns the bus to the host.
- R4: An owner other than 1111 that has not yet shown any bus activity (burst, cmd, or a status line low) since its grant is not preempted through the normal path.
- R5: An arbitration is not started while any of burst = 1, cmd = 1, s0_n = 0 or s1_n = 0 holds. With the synchronised preempt already active, arb_gnt rises on the first edge after the last of these signals goes inactive, whatever order they are released in.
- R6: If burst = 1 and the synchronised preempt is active on TMO_CYC consecutive edges, arbitration is forced on the last of those edges and tmo_err is set. A drop of burst restarts the count. TMO_CYC = CLK_MHZ*TMO_NS/1000.
- R7: tmo_err stays at 1 until err_clr is sampled high, and it reads 0 after that edge.
- R8: While preempt_n stays high, arb_gnt stays 0 and owner does not change.
- R9: preempt is ignored during the arbitration window, so holding preempt_n low does not change the window length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preempt_n | input | 1 | Active-low bus request, asynchronous |
| arb_bus | input | 4 | Resolved wired-AND arbitration vector |
| burst | input | 1 | Owner is bursting (active high) |
| cmd | input | 1 | Bus command active (active high) |
| s0_n | input | 1 | Bus-cycle status 0, active low |
| s1_n | input | 1 | Bus-cycle status 1, active low |
| err_clr | input | 1 | Clears the timeout flag |
| arb_gnt | output | 1 | 1 = arbitration window, 0 = grant |
| owner | output | 4 | Vector of the current bus owner |
| tmo_err | output | 1 | Sticky burst-timeout error/NMI |

## Verification
A change on preempt_n reaches arb_gnt after three rising edges: two synchroniser stages and one state register. A release of the last busy signal shows after a single edge, because burst, cmd and status are used without delay. The window closes ARB_CYC edges after it opens, and owner updates on that same closing edge. The timeout fires on the TMO_CYC-th edge that sees burst together with the synchronised preempt. Every bench check drives inputs just after a falling edge and then counts the exact number of falling edges to the due cycle. It also checks the cycle just before, so that a result arriving one cycle early or late is reported.

// File: rtl/bus_arb_central.sv
`timescale 1ns/1ps
module bus_arb_central #(
  parameter int VEC_W   = 4,
  parameter int ARB_CYC = 4,
  parameter int CLK_MHZ = 125,
  parameter int TMO_NS  = 7800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preempt_n,
  input  logic [VEC_W-1:0] arb_bus,
  input  logic             burst,
  input  logic             cmd,
  input  logic             s0_n,
  input  logic             s1_n,
  input  logic             err_clr,
  output logic             arb_gnt,
  output logic [VEC_W-1:0] owner,
  output logic             tmo_err
);
  localparam int TMO_CYC = CLK_MHZ * TMO_NS / 1000;
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int AW = $clog2(ARB_CYC + 1);
  localparam logic [VEC_W-1:0] HOST_VEC = '1;

  logic [1:0]       sync_q;
  logic             in_arb, seen_q, err_q;
  logic [AW-1:0]    wcnt;
  logic [TW-1:0]    tcnt;
  logic [VEC_W-1:0] owner_q;

  wire pre     = ~sync_q[1];
  wire busy    = burst | cmd | ~s0_n | ~s1_n;
  wire done    = pre & ~busy & (seen_q | (owner_q == HOST_VEC));
  wire stall   = pre & burst;
  wire tmo_hit = stall && (tcnt == TW'(TMO_CYC - 1));

  assign arb_gnt = in_arb;
  assign owner   = owner_q;
  assign tmo_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], preempt_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_arb  <= 1'b0;
      seen_q  <= 1'b0;
      wcnt    <= '0;
      tcnt    <= '0;
      owner_q <= HOST_VEC;
      err_q   <= 1'b0;
    end else begin
      if (in_arb) begin
        seen_q <= 1'b0;
        tcnt   <= '0;
        if (wcnt == AW'(ARB_CYC - 1)) begin
          in_arb  <= 1'b0;
          owner_q <= arb_bus;
        end else begin
          wcnt <= wcnt + AW'(1);
        end
      end else if (done || tmo_hit) begin
        in_arb <= 1'b1;
        wcnt   <= '0;
        tcnt   <= '0;
        seen_q <= 1'b0;
      end else begin
        seen_q <= seen_q | busy;
        tcnt   <= stall ? tcnt + TW'(1) : '0;
      end
      if (tmo_hit && !in_arb) err_q <= 1'b1;
      else if (err_clr)       err_q <= 1'b0;
    end
  end

  // R3
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_arb |-> (wcnt < AW'(ARB_CYC)));
  // R3
  owner_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_gnt) |-> (owner == $past(arb_bus)));
  // R8
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arb_gnt) |-> $stable(owner));
  // R2
  arb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_gnt) |-> !$past(sync_q[1]));
  // R6
  err_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> $rose(arb_gnt));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !err_clr) |=> tmo_err);
endmodule

// File: tb/test_bus_arb_central.sv
`timescale 1ns/1ps
module test_bus_arb_central;
  localparam int ARB_CYC = 4;
  localparam int CLK_MHZ = 125;
  localparam int TMO_NS  = 7800;
  localparam int TMO_CYC = CLK_MHZ * TMO_NS / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic preempt_n = 1'b1, burst = 1'b0, cmd = 1'b0, s0_n = 1'b1, s1_n = 1'b1, err_clr = 1'b0;
  logic [3:0] arb_bus = 4'hF;
  logic arb_gnt, tmo_err;
  logic [3:0] owner;
  int n_chk = 0, n_bad = 0;
  logic [3:0] exp_owner = 4'hF;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_arb_central #(.VEC_W(4), .ARB_CYC(ARB_CYC), .CLK_MHZ(CLK_MHZ), .TMO_NS(TMO_NS)) i_bus_arb_central (
    .clk(clk), .rst_n(rst_n), .preempt_n(preempt_n), .arb_bus(arb_bus), .burst(burst),
    .cmd(cmd), .s0_n(s0_n), .s1_n(s1_n), .err_clr(err_clr),
    .arb_gnt(arb_gnt), .owner(owner), .tmo_err(tmo_err));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pick_vec(input bit not_host);
    logic [3:0] v;
    v = 4'($urandom_range(0, not_host ? 14 : 15));
    return v;
  endfunction

  task automatic release_sig(input int idx);
    case (idx)
      0: burst = 1'b0;
      1: cmd   = 1'b0;
      2: s0_n  = 1'b1;
      default: s1_n = 1'b1;
    endcase
  endtask

  task automatic round(input logic [3:0] v, input bit hold_pre);
    logic [3:0] m;
    int r;
    if (exp_owner == 4'hF) begin
      preempt_n = 1'b0;
      step(2); chk("R2 early", 32'(arb_gnt), 0);
      step(1); chk("R2 rise", 32'(arb_gnt), 1);
    end else begin
      m = 4'($urandom_range(1, 15));
      burst = m[0]; cmd = m[1]; s0_n = ~m[2]; s1_n = ~m[3];
      preempt_n = 1'b0;
      step(2 + $urandom_range(1, 4));
      chk("R4 busy", 32'(arb_gnt), 0);
      r = $urandom_range(0, 3);
      for (int k = 0; k < 4; k++) begin
        if (m[(r + k) % 4]) begin
          chk("R5 hold", 32'(arb_gnt), 0);
          release_sig((r + k) % 4);
          step(1);
        end
      end
      chk("R5 rise", 32'(arb_gnt), 1);
    end
    arb_bus = v;
    if (hold_pre) begin
      step(ARB_CYC - 1); chk("R9 window", 32'(arb_gnt), 1);
      step(1);           chk("R9 close", 32'(arb_gnt), 0);
      chk("R9 owner", 32'(owner), 32'(v));
      arb_bus = 4'hF;
      step(4); chk("R9 no rearb", 32'(arb_gnt), 0);
      preempt_n = 1'b1;
    end else begin
      preempt_n = 1'b1;
      step(ARB_CYC - 1); chk("R3 window", 32'(arb_gnt), 1);
      step(1);           chk("R3 close", 32'(arb_gnt), 0);
      chk("R3 owner", 32'(owner), 32'(v));
      arb_bus = 4'hF;
    end
    exp_owner = v;
    step(3);
  endtask

  initial begin
    void'($urandom(32'd1234));
    step(3);
    chk("R1 gnt", 32'(arb_gnt), 0);
    chk("R1 owner", 32'(owner), 32'hF);
    chk("R1 err", 32'(tmo_err), 0);
    rst_n = 1'b1;
    step(1);
    for (int i = 0; i < 20; i++) begin
      step(1);
      chk("R8 gnt", 32'(arb_gnt), 0);
      chk("R8 owner", 32'(owner), 32'hF);
    end
    round(4'hF, 1'b0);
    for (int i = 0; i < 24; i++) round(pick_vec(1'b0), 1'b0);
    round(4'h5, 1'b0);
    preempt_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step(1); chk("R4 idle owner", 32'(arb_gnt), 0);
    end
    round(4'h3, 1'b1);
    chk("R9 owner kept", 32'(owner), 32'h3);

    burst = 1'b1; preempt_n = 1'b0;
    step(TMO_CYC + 1);
    chk("R6 not yet", 32'(arb_gnt), 0);
    chk("R6 err not yet", 32'(tmo_err), 0);
    step(1);
    chk("R6 forced", 32'(arb_gnt), 1);
    chk("R6 err", 32'(tmo_err), 1);
    burst = 1'b0; preempt_n = 1'b1;
    step(ARB_CYC);
    chk("R3 host back", 32'(owner), 32'hF);
    exp_owner = 4'hF;
    step(5);
    chk("R7 sticky", 32'(tmo_err), 1);
    err_clr = 1'b1; step(1); err_clr = 1'b0;
    chk("R7 cleared", 32'(tmo_err), 0);

    round(4'h6, 1'b0);
    cmd = 1'b1; burst = 1'b1; preempt_n = 1'b0;
    step(TMO_CYC / 2);
    burst = 1'b0;
    step(3);
    chk("R6 gap no err", 32'(tmo_err), 0);
    burst = 1'b1;
    step(TMO_CYC - 1);
    chk("R6 restart early", 32'(arb_gnt), 0);
    step(1);
    chk("R6 restart fire", 32'(arb_gnt), 1);
    chk("R6 restart err", 32'(tmo_err), 1);
    burst = 1'b0; cmd = 1'b0; preempt_n = 1'b1;
    step(ARB_CYC + 2);
    exp_owner = 4'hF;
    err_clr = 1'b1; step(1); err_clr = 1'b0;
    chk("R7 cleared again", 32'(tmo_err), 0);
    for (int i = 0; i < 8; i++) round(pick_vec(1'b0), 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule